// File: doc/BRIEF.md
# Event Readout Builder with Zero Suppression

The builder turns completed events into a flat output stream. A separate completion queue holds event IDs whose channel data is already sitting in per-channel partitions of a shared RAM. For each ID it takes from that queue, the builder first writes a presence word, then walks the enabled channels in index order. For each enabled channel it copies words from that channel's partition, up to and including the channel trailer. It closes the event with a summary trailer. The output goes into an internal data FIFO, and a one-entry event summary goes into an internal length FIFO. A downstream reader drains both FIFOs.

Each channel keeps its own read pointer, so partitions are consumed one event at a time and never rewound. Optional zero suppression removes channels that carry no hits. A programmable word cap bounds the size of an event. Words beyond the cap are still consumed from the partition but are discarded. Configuration inputs must be held stable while an event is in progress.

Top module: `erb_builder`

## Requirements
- R1: When the completion queue is not empty and the builder is idle, the builder pops exactly one ID, and events are emitted in queue order.
- R2: The first word of every event is `{hdr_pat_i, chan_en_i}`, where bit c of the low NCH bits flags channel c as present.
- R3: Channels are visited in ascending index order. No RAM read is ever issued to a channel whose `chan_en_i` bit is 0.
- R4: For an enabled channel, words are read from the channel's current pointer up to and including the first word with bits [31:28] = 0xC (trailer). Bits [31:28] = 0xA mark a header. The pointer is left just past the trailer.
- R5: With `zs_en_i`=1, a header directly followed by a trailer in the same partition is not output. With `zs_en_i`=0, or when any other word follows the header, all words are output unchanged.
- R6: The last word of every event is `{trl_pat_i[7:0], count[11:0], id[11:0]}`. Here count is the number of words written for the event, including the presence word and this trailer.
- R7: After the trailer word, one length entry `{id[11:0], count[11:0]}` is pushed per event.
- R8: At most `max_words_i` words (presence plus channel words) are written before the trailer. Channel words past the cap are still consumed up to the trailer but are discarded. The trailer is still appended. `rdmax_irq_o` pulses for exactly one cycle in an event that discarded words.
- R9: The data FIFO and the length FIFO are 128 entries deep with first-word-fall-through read ports. The builder stalls while the FIFO it must write is full, and no word is lost.
- R10: Each channel read pointer wraps modulo PART_DEPTH (default 8192), so partitions behave as rings.
- R11: After reset both FIFOs are empty, all pointers are 0, `rdmax_irq_o` is low, and no pop or RAM read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_empty_i | input | 1 | Completion queue empty |
| cmp_id_i | input | ID_W | Head ID of the completion queue |
| cmp_rd_o | output | 1 | Pop the completion queue |
| ram_rd_o | output | 1 | Partition RAM read strobe; data returns the next cycle |
| ram_addr_o | output | CH_W+PTR_W | {channel, pointer} read address |
| ram_data_i | input | DW | Partition RAM read data |
| hdr_pat_i | input | DW-NCH | Upper bits of the presence word |
| trl_pat_i | input | DW-CNT_W-ID_W | Upper bits of the event trailer |
| chan_en_i | input | NCH | Channel present flags |
| zs_en_i | input | 1 | Zero suppression enable |
| max_words_i | input | CNT_W | Word cap before the trailer (at least 1) |
| dat_rd_i | input | 1 | Pop the data FIFO |
| dat_o | output | DW | Data FIFO head |
| dat_empty_o | output | 1 | Data FIFO empty |
| len_rd_i | input | 1 | Pop the length FIFO |
| len_o | output | ID_W+CNT_W | Length FIFO head {id, count} |
| len_empty_o | output | 1 | Length FIFO empty |
| rdmax_irq_o | output | 1 | Word cap reached, one-cycle pulse |

## Verification
A read pointer that drifts shows up in the first word of the next event that uses the channel. Either a header from the wrong event appears, or the channel never reaches its trailer and the length entry never arrives. A wrong word counter shows up only in the event trailer and the length entry of the same event. A wrong suppression hold or cap flag corrupts the data stream within the same event, by dropping or duplicating a header, or by producing a word count that disagrees with the words drained. Stall faults show as missing IDs once a FIFO has filled, so the bench deliberately fills each FIFO before draining it.

// File: rtl/erb_pkg.sv
package erb_pkg;
  localparam logic [3:0] HDR_NIB = 4'hA;
  localparam logic [3:0] TRL_NIB = 4'hC;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRES, ST_SEL, ST_ISSUE, ST_CAP, ST_PROC, ST_FLUSH, ST_TRAIL, ST_LEN
  } erb_state_e;
endpackage

// File: rtl/erb_fifo.sv
module erb_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] din_i,
  output logic         full_o,
  input  logic         rd_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  wp_q, rp_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wp_q[AW-1:0]] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (wr_i) wp_q <= wp_q + (AW+1)'(1);
      if (rd_i) rp_q <= rp_q + (AW+1)'(1);
    end
  end

  assign full_o  = (wp_q - rp_q) == (AW+1)'(DEPTH);
  assign empty_o = wp_q == rp_q;
  assign dout_o  = mem_q[rp_q[AW-1:0]];

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !full_o);
  assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> !empty_o);
endmodule

// File: rtl/erb_chan_ptrs.sv
module erb_chan_ptrs #(
  parameter int NCH   = 6,
  parameter int PTR_W = 13,
  parameter int CH_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [CH_W-1:0]  sel_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam int NSLOT = 2 ** CH_W;

  logic [NSLOT-1:0][PTR_W-1:0] ptr_all;

  for (genvar c = 0; c < NSLOT; c++) begin : g_ch
    if (c < NCH) begin : g_live
      logic [PTR_W-1:0] p_q;
      // power-of-two depth: natural overflow is the ring wrap
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) p_q <= '0;
        else if (inc_i && sel_i == CH_W'(c)) p_q <= p_q + PTR_W'(1);
      end
      assign ptr_all[c] = p_q;
    end else begin : g_pad
      assign ptr_all[c] = '0;
    end
  end

  assign ptr_o = ptr_all[sel_i];
endmodule

// File: rtl/erb_ctrl.sv
module erb_ctrl
  import erb_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NCH   = 6,
  parameter int ID_W  = 12,
  parameter int CNT_W = 12,
  parameter int CH_W  = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmp_empty_i,
  input  logic [ID_W-1:0]          cmp_id_i,
  output logic                     cmp_rd_o,
  output logic                     ram_rd_o,
  output logic [CH_W-1:0]          chan_o,
  input  logic [DW-1:0]            ram_data_i,
  input  logic [DW-NCH-1:0]        hdr_pat_i,
  input  logic [DW-CNT_W-ID_W-1:0] trl_pat_i,
  input  logic [NCH-1:0]           chan_en_i,
  input  logic                     zs_en_i,
  input  logic [CNT_W-1:0]         max_words_i,
  input  logic                     dat_full_i,
  output logic                     dat_push_o,
  output logic [DW-1:0]            dat_word_o,
  input  logic                     len_full_i,
  output logic                     len_push_o,
  output logic [ID_W+CNT_W-1:0]    len_word_o,
  output logic                     rdmax_irq_o
);
  localparam int CI_W = $clog2(NCH + 1);
  localparam int EN_W = 2 ** CI_W;

  erb_state_e        st_q;
  logic [CI_W-1:0]   chan_q;
  logic [ID_W-1:0]   id_q;
  logic [CNT_W-1:0]  cnt_q, cnt_inc;
  logic [DW-1:0]     wrd_q, hdr_q, emit_word;
  logic              hold_q, capped_q, irq_q;
  logic              emit_req, room, drop, trl_push, is_hdr, is_trl;
  logic [EN_W-1:0]   en_pad;

  assign en_pad  = EN_W'(chan_en_i);
  assign is_hdr  = wrd_q[DW-1 -: 4] == HDR_NIB;
  assign is_trl  = wrd_q[DW-1 -: 4] == TRL_NIB;
  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    emit_req  = 1'b0;
    emit_word = wrd_q;
    unique case (st_q)
      ST_PRES: begin
        emit_req  = !dat_full_i;
        emit_word = {hdr_pat_i, chan_en_i};
      end
      ST_PROC:  emit_req = !hold_q && !(zs_en_i && is_hdr) && !dat_full_i;
      ST_FLUSH: begin
        emit_req  = !dat_full_i;
        emit_word = hdr_q;
      end
      default: ;
    endcase
  end

  assign room       = cnt_q < max_words_i;
  assign drop       = emit_req && !room;
  assign trl_push   = (st_q == ST_TRAIL) && !dat_full_i;
  assign dat_push_o = (emit_req && room) || trl_push;
  assign dat_word_o = trl_push ? {trl_pat_i, cnt_inc, id_q} : emit_word;
  assign len_push_o = (st_q == ST_LEN) && !len_full_i;
  assign len_word_o = {id_q, cnt_q};
  assign cmp_rd_o   = (st_q == ST_IDLE) && !cmp_empty_i;
  assign ram_rd_o   = st_q == ST_ISSUE;
  assign chan_o     = chan_q[CH_W-1:0];
  assign rdmax_irq_o = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      chan_q   <= '0;
      id_q     <= '0;
      cnt_q    <= '0;
      wrd_q    <= '0;
      hdr_q    <= '0;
      hold_q   <= 1'b0;
      capped_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= drop && !capped_q;
      if (drop) capped_q <= 1'b1;
      if (emit_req && room) cnt_q <= cnt_inc;
      unique case (st_q)
        ST_IDLE: if (!cmp_empty_i) begin
          id_q     <= cmp_id_i;
          cnt_q    <= '0;
          chan_q   <= '0;
          hold_q   <= 1'b0;
          capped_q <= 1'b0;
          st_q     <= ST_PRES;
        end
        ST_PRES: if (!dat_full_i) st_q <= ST_SEL;
        ST_SEL: begin
          if (chan_q == CI_W'(NCH)) st_q <= ST_TRAIL;
          else if (en_pad[chan_q])  st_q <= ST_ISSUE;
          else                      chan_q <= chan_q + CI_W'(1);
        end
        ST_ISSUE: st_q <= ST_CAP;
        ST_CAP: begin
          wrd_q <= ram_data_i;
          st_q  <= ST_PROC;
        end
        ST_PROC: begin
          if (hold_q) begin
            if (zs_en_i && is_trl) begin
              hold_q <= 1'b0;           // empty channel: drop header and trailer
              chan_q <= chan_q + CI_W'(1);
              st_q   <= ST_SEL;
            end else begin
              st_q <= ST_FLUSH;
            end
          end else if (zs_en_i && is_hdr) begin
            hold_q <= 1'b1;
            hdr_q  <= wrd_q;
            st_q   <= ST_ISSUE;
          end else if (!dat_full_i) begin
            if (is_trl) begin
              chan_q <= chan_q + CI_W'(1);
              st_q   <= ST_SEL;
            end else begin
              st_q <= ST_ISSUE;
            end
          end
        end
        ST_FLUSH: if (!dat_full_i) begin
          hold_q <= 1'b0;
          st_q   <= ST_PROC;
        end
        ST_TRAIL: if (!dat_full_i) begin
          cnt_q <= cnt_inc;
          st_q  <= ST_LEN;
        end
        ST_LEN: if (!len_full_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_irq_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdmax_irq_o |=> !rdmax_irq_o);
  assert_one_pop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_rd_o |=> !cmp_rd_o);
endmodule

// File: rtl/erb_builder.sv
module erb_builder #(
  parameter int DW          = 32,
  parameter int NCH         = 6,
  parameter int ID_W        = 12,
  parameter int CNT_W       = 12,
  parameter int PART_DEPTH  = 8192,
  parameter int DFIFO_DEPTH = 128,
  parameter int LFIFO_DEPTH = 128,
  localparam int CH_W   = $clog2(NCH),
  localparam int PTR_W  = $clog2(PART_DEPTH),
  localparam int RA_W   = CH_W + PTR_W,
  localparam int LW     = ID_W + CNT_W,
  localparam int TPAT_W = DW - CNT_W - ID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_empty_i,
  input  logic [ID_W-1:0]   cmp_id_i,
  output logic              cmp_rd_o,
  output logic              ram_rd_o,
  output logic [RA_W-1:0]   ram_addr_o,
  input  logic [DW-1:0]     ram_data_i,
  input  logic [DW-NCH-1:0] hdr_pat_i,
  input  logic [TPAT_W-1:0] trl_pat_i,
  input  logic [NCH-1:0]    chan_en_i,
  input  logic              zs_en_i,
  input  logic [CNT_W-1:0]  max_words_i,
  input  logic              dat_rd_i,
  output logic [DW-1:0]     dat_o,
  output logic              dat_empty_o,
  input  logic              len_rd_i,
  output logic [LW-1:0]     len_o,
  output logic              len_empty_o,
  output logic              rdmax_irq_o
);
  logic [CH_W-1:0]  chan;
  logic [PTR_W-1:0] ptr;
  logic             dat_full, dat_push, len_full, len_push;
  logic [DW-1:0]    dat_word;
  logic [LW-1:0]    len_word;
  logic [2**CH_W-1:0] en_pad;

  erb_ctrl #(.DW(DW), .NCH(NCH), .ID_W(ID_W), .CNT_W(CNT_W), .CH_W(CH_W)) u_ctrl (
    .clk_i, .rst_ni, .cmp_empty_i, .cmp_id_i, .cmp_rd_o, .ram_rd_o,
    .chan_o(chan), .ram_data_i, .hdr_pat_i, .trl_pat_i, .chan_en_i, .zs_en_i,
    .max_words_i, .dat_full_i(dat_full), .dat_push_o(dat_push), .dat_word_o(dat_word),
    .len_full_i(len_full), .len_push_o(len_push), .len_word_o(len_word), .rdmax_irq_o
  );

  erb_chan_ptrs #(.NCH(NCH), .PTR_W(PTR_W), .CH_W(CH_W)) u_ptrs (
    .clk_i, .rst_ni, .inc_i(ram_rd_o), .sel_i(chan), .ptr_o(ptr)
  );

  erb_fifo #(.W(DW), .DEPTH(DFIFO_DEPTH)) u_dfifo (
    .clk_i, .rst_ni, .wr_i(dat_push), .din_i(dat_word), .full_o(dat_full),
    .rd_i(dat_rd_i), .dout_o(dat_o), .empty_o(dat_empty_o)
  );

  erb_fifo #(.W(LW), .DEPTH(LFIFO_DEPTH)) u_lfifo (
    .clk_i, .rst_ni, .wr_i(len_push), .din_i(len_word), .full_o(len_full),
    .rd_i(len_rd_i), .dout_o(len_o), .empty_o(len_empty_o)
  );

  assign ram_addr_o = {chan, ptr};
  assign en_pad     = (2**CH_W)'(chan_en_i);

  assert_absent_skip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_rd_o |-> en_pad[ram_addr_o[RA_W-1 -: CH_W]]);
  assert_len_after_trl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_push |-> !dat_push);
endmodule

// File: tb/tb_erb_builder.sv
module tb_erb_builder;
  localparam int NCH = 6;
  localparam int PD  = 16;
  localparam logic [25:0] HP = 26'h2A5A5A5;
  localparam logic [7:0]  TP = 8'hE7;
  // {chan_en[5:0], zs, max[11:0]}
  localparam logic [18:0] VEC [8] = '{
    {6'h3F, 1'b0, 12'd100}, {6'h3F, 1'b1, 12'd100}, {6'h15, 1'b1, 12'd100},
    {6'h00, 1'b0, 12'd100}, {6'h3F, 1'b0, 12'd5},   {6'h2A, 1'b1, 12'd100},
    {6'h3F, 1'b1, 12'd1},   {6'h21, 1'b0, 12'd100}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmp_empty, cmp_rd, ram_rd, zs_en = 1'b0, dat_rd = 1'b0, dat_empty;
  logic len_rd = 1'b0, len_empty, irq;
  logic [11:0] cmp_id, max_words = 12'd100;
  logic [6:0]  ram_addr;
  logic [31:0] ram_q = '0, dat;
  logic [25:0] hdr_pat = HP;
  logic [7:0]  trl_pat = TP;
  logic [5:0]  chan_en = '0;
  logic [23:0] len;
  logic [7:0]  en8;

  always #5 clk = ~clk;

  erb_builder #(.NCH(NCH), .PART_DEPTH(PD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_empty_i(cmp_empty), .cmp_id_i(cmp_id),
    .cmp_rd_o(cmp_rd), .ram_rd_o(ram_rd), .ram_addr_o(ram_addr), .ram_data_i(ram_q),
    .hdr_pat_i(hdr_pat), .trl_pat_i(trl_pat), .chan_en_i(chan_en), .zs_en_i(zs_en),
    .max_words_i(max_words), .dat_rd_i(dat_rd), .dat_o(dat), .dat_empty_o(dat_empty),
    .len_rd_i(len_rd), .len_o(len), .len_empty_o(len_empty), .rdmax_irq_o(irq)
  );

  logic [31:0] mem [128];
  logic [11:0] cq [512];
  int cq_wr = 0, cq_rd = 0, irq_cnt = 0, bad_rd = 0;
  int wp [NCH];
  int checks = 0, errs = 0;
  logic [31:0] exp_w [300], got_w [300];
  logic [23:0] got_l [300];
  int ne, nw, nl, cnt_m, exp_irq;

  assign cmp_empty = cq_rd == cq_wr;
  assign cmp_id    = cq[cq_rd[8:0]];
  assign en8       = {2'b00, chan_en};

  always @(posedge clk) begin
    if (cmp_rd) cq_rd <= cq_rd + 1;
    if (ram_rd) ram_q <= mem[ram_addr];
    if (irq) irq_cnt <= irq_cnt + 1;
    if (ram_rd && !en8[ram_addr[6:4]]) bad_rd <= bad_rd + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic add_exp(input logic [31:0] w);
    if (cnt_m < int'(max_words)) begin
      exp_w[ne] = w;
      ne++;
      cnt_m++;
    end else exp_irq = 1;
  endtask

  task automatic put(input int c, input logic [31:0] w);
    mem[c*PD + wp[c]] = w;
    wp[c] = (wp[c] + 1) % PD;
  endtask

  task automatic push_id(input logic [11:0] id);
    cq[cq_wr[8:0]] = id;
    cq_wr++;
  endtask

  task automatic drain(input int want_w, input int want_l, input bit take_len, input int maxcyc);
    nw = 0;
    nl = 0;
    for (int k = 0; k < maxcyc; k++) begin
      @(negedge clk);
      dat_rd = !dat_empty && nw < want_w;
      len_rd = take_len && !len_empty && nl < want_l;
      if (dat_rd) begin got_w[nw] = dat; nw++; end
      if (len_rd) begin got_l[nl] = len; nl++; end
      if (nw >= want_w && (!take_len || nl >= want_l)) break;
    end
    @(negedge clk);
    dat_rd = 1'b0;
    len_rd = 1'b0;
  endtask

  task automatic run_event(input int ev, input logic [18:0] v);
    logic [11:0] id;
    int i0, n;
    id = 12'(100 + ev);
    @(negedge clk);
    chan_en = v[18:13];
    zs_en = v[12];
    max_words = v[11:0];
    ne = 0; cnt_m = 0; exp_irq = 0;
    add_exp({HP, v[18:13]});
    for (int c = 0; c < NCH; c++) begin
      if (v[13+c]) begin
        n = (ev + c) % 3;
        put(c, {4'hA, 4'(c), 24'(ev)});
        for (int d = 0; d < n; d++) put(c, {4'h3, 4'(c), 8'(d), 16'(ev)});
        put(c, {4'hC, 4'(c), 24'(ev)});
        if (!(v[12] && n == 0)) begin
          add_exp({4'hA, 4'(c), 24'(ev)});
          for (int d = 0; d < n; d++) add_exp({4'h3, 4'(c), 8'(d), 16'(ev)});
          add_exp({4'hC, 4'(c), 24'(ev)});
        end
      end
    end
    exp_w[ne] = {TP, 12'(cnt_m + 1), id};
    ne++;
    i0 = irq_cnt;
    push_id(id);
    drain(ne, 1, 1'b1, 3000);
    chk(nw == ne, "R4 R5 R8 word count", 32'(nw), 32'(ne));
    for (int k = 0; k < nw && k < ne; k++) begin
      if (k == 0) chk(got_w[k] == exp_w[k], "R2 presence", got_w[k], exp_w[k]);
      else if (k == ne - 1) chk(got_w[k] == exp_w[k], "R6 trailer", got_w[k], exp_w[k]);
      else chk(got_w[k] == exp_w[k], "R4 R5 R8 R10 channel word", got_w[k], exp_w[k]);
    end
    chk(nl == 1 && got_l[0] == {id, 12'(cnt_m + 1)}, "R7 length entry",
        32'(got_l[0]), 32'({id, 12'(cnt_m + 1)}));
    repeat (3) @(negedge clk);
    chk(dat_empty && len_empty, "R4 no extra words", 32'({dat_empty, len_empty}), 32'h3);
    chk(irq_cnt - i0 == exp_irq, "R8 irq pulses", 32'(irq_cnt - i0), 32'(exp_irq));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int base;
    for (int c = 0; c < NCH; c++) wp[c] = 0;
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(dat_empty && len_empty, "R11 fifos empty", 32'({dat_empty, len_empty}), 32'h3);
    chk(!cmp_rd && !ram_rd, "R11 no requests", 32'({cmp_rd, ram_rd}), 32'h0);
    chk(!irq, "R11 irq low", 32'(irq), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!cmp_rd && cq_rd == 0, "R1 no pop while queue empty", 32'(cq_rd), 32'h0);

    for (int rep = 0; rep < 2; rep++)
      for (int i = 0; i < 8; i++) run_event(rep * 8 + i, VEC[i]);

    // R9 data FIFO full: 2-word events, no draining
    @(negedge clk);
    chan_en = '0; zs_en = 1'b0; max_words = 12'd100;
    base = cq_rd;
    for (int i = 0; i < 70; i++) push_id(12'(1000 + i));
    repeat (1500) @(negedge clk);
    chk(cq_rd - base == 65, "R9 stall on data full", 32'(cq_rd - base), 32'd65);
    drain(140, 70, 1'b1, 5000);
    chk(nw == 140 && nl == 70, "R9 no loss after data stall", 32'(nw), 32'd140);
    for (int i = 0; i < nw && i < 140; i++)
      if (i % 2 == 0) chk(got_w[i] == {HP, 6'b0}, "R2 presence bulk", got_w[i], {HP, 6'b0});
      else chk(got_w[i] == {TP, 12'd2, 12'(1000 + i/2)}, "R6 trailer bulk", got_w[i],
               {TP, 12'd2, 12'(1000 + i/2)});
    for (int i = 0; i < nl && i < 70; i++)
      chk(got_l[i] == {12'(1000 + i), 12'd2}, "R1 R7 order", 32'(got_l[i]),
          32'({12'(1000 + i), 12'd2}));

    // R9 length FIFO full: data drained, lengths held
    base = cq_rd;
    for (int i = 0; i < 130; i++) push_id(12'(2000 + i));
    drain(258, 0, 1'b0, 3000);
    repeat (50) @(negedge clk);
    chk(nw == 258, "R9 data words before length stall", 32'(nw), 32'd258);
    chk(cq_rd - base == 129, "R9 stall on length full", 32'(cq_rd - base), 32'd129);
    chk(dat_empty, "R9 nothing past stalled event", 32'(dat_empty), 32'h1);
    drain(2, 130, 1'b1, 5000);
    chk(nl == 130 && nw == 2, "R9 no loss after length stall", 32'(nl), 32'd130);
    for (int i = 0; i < nl && i < 130; i++)
      chk(got_l[i] == {12'(2000 + i), 12'd2}, "R7 length bulk", 32'(got_l[i]),
          32'({12'(2000 + i), 12'd2}));
    chk(got_w[1] == {TP, 12'd2, 12'd2129}, "R6 last trailer", got_w[1], {TP, 12'd2, 12'd2129});

    chk(bad_rd == 0, "R3 absent partitions untouched", 32'(bad_rd), 32'h0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule